// File: doc/BRIEF.md
# Way-Predicted Four-Way Read Cache

This block is a four-way set-associative read cache that keeps one predicted way for each set. When a request is accepted, the next cycle reads the tag and data of the predicted way only. The output selection is set to that way, so a correct guess returns data one cycle after the request, using one tag read and one data read. If the predicted way misses, the cache reads the other three ways together in the following cycle. That cycle ends in either a slow hit or a miss. A correct guess therefore costs one tag and one data access, and a wrong guess costs an extra probe cycle.

Misses are not refilled by the cache itself. An external agent writes lines through a separate fill port. The cache chooses the way to overwrite with a round-robin pointer kept per set. The predictor moves to the hitting way on a slow hit and to the filled way on a refill. Two counters record how often the first probe was right and how often it was wrong.

Each line holds one word. The set index is `req_addr_i[IDX_W-1:0]` and the tag is the remaining upper address bits.

Top module: `wp_cache`

## Requirements
- R1: After reset, no line is valid, every set predicts way 0, the round-robin pointer of every set is at way 0, both counters read 0, `req_ready_o` and `fill_ready_o` are 1, and no tag or data enable is active.
- R2: In the cycle after a request is accepted, exactly one bit of `tag_rd_en_o` is set, that bit is the set's predicted way (bit n means way n), and `data_rd_en_o` equals `tag_rd_en_o`. If that way holds a valid line with a matching tag, `rsp_valid_o` and `rsp_fast_o` are 1 in that cycle and `rsp_data_o` carries the line's data.
- R3: If the predicted way does not hit, no response is given in that cycle. In the next cycle `tag_rd_en_o` and `data_rd_en_o` are the complement of the predicted one-hot, and the response is given: a slow hit with that way's data, or a miss.
- R4: A slow hit changes the set's prediction to the hitting way. The next request to the same line is then a fast hit.
- R5: A fill writes the set's round-robin victim, which advances way 0, 1, 2, 3 and then wraps back to 0. The fill sets the prediction to the filled way, and the line that was overwritten no longer hits.
- R6: A fill is accepted only when no request is in flight (`fill_ready_o` is 1 exactly when idle). `req_ready_o` is 0 while `fill_valid_i` is 1, so a fill wins over a request in the same cycle.
- R7: At most one of `rsp_fast_o`, `rsp_slow_o` and `rsp_miss_o` is 1, and `rsp_valid_o` is 1 exactly when one of them is. `rsp_data_o` is 0 on a miss.
- R8: `pred_ok_cnt_o` increments on each fast hit. `pred_bad_cnt_o` increments on each slow hit and on each miss.
- R9: Predictions, victim pointers and lines of one set are not affected by accesses or fills to other sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request valid |
| req_ready_o | output | 1 | Cache can accept a read request |
| req_addr_i | input | ADDR_W | Read address |
| rsp_valid_o | output | 1 | Response valid this cycle |
| rsp_data_o | output | DATA_W | Read data (0 on miss) |
| rsp_fast_o | output | 1 | Hit in the predicted way |
| rsp_slow_o | output | 1 | Hit in another way, second cycle |
| rsp_miss_o | output | 1 | No way holds the address |
| fill_valid_i | input | 1 | Refill write valid |
| fill_ready_o | output | 1 | Refill is accepted this cycle |
| fill_addr_i | input | ADDR_W | Refill address |
| fill_data_i | input | DATA_W | Refill data |
| tag_rd_en_o | output | 4 | Per-way tag read enables |
| data_rd_en_o | output | 4 | Per-way data read enables |
| pred_ok_cnt_o | output | CNT_W | Correct-prediction count |
| pred_bad_cnt_o | output | CNT_W | Wrong-prediction count |

## Verification
The assertions assume that the agent driving the cache never fills a line whose address is already resident, so at most one way of a set can match a given tag. The stimulus meets this by filling only addresses that have just missed or that are known to be absent. The assertions also assume the counters do not wrap during a run, because each increment is checked against the previous value plus one. The stimulus stays far below the counter range. Inputs change only between clock edges, and requests are held until they are accepted.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = 2;
  typedef enum logic [1:0] {ST_IDLE, ST_PRED, ST_REST} wp_state_e;
endpackage

// File: rtl/wp_way_bank.sv
module wp_way_bank #(
  parameter int SETS   = 8,
  parameter int TAG_W  = 13,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i]  <= wr_tag_i;
      data_q[wr_idx_i] <= wr_data_i;
    end
  end

  // unread banks present nothing: no compare, no data
  assign hit_o     = rd_en_i && valid_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i);
  assign rd_data_o = rd_en_i ? data_q[rd_idx_i] : '0;
endmodule

// File: rtl/wp_pred_table.sv
module wp_pred_table
  import wp_pkg::*;
#(
  parameter int SETS = 8,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [WAY_W-1:0] pred_way_o,
  input  logic             fill_en_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  output logic [WAY_W-1:0] victim_way_o,
  input  logic             upd_en_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic [WAY_W-1:0] upd_way_i
);
  logic [WAY_W-1:0] pred_q [SETS];
  logic [WAY_W-1:0] rr_q   [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        pred_q[s] <= '0;
        rr_q[s]   <= '0;
      end
    end else if (fill_en_i) begin
      pred_q[fill_idx_i] <= rr_q[fill_idx_i];
      rr_q[fill_idx_i]   <= rr_q[fill_idx_i] + 1'b1;
    end else if (upd_en_i) begin
      pred_q[upd_idx_i] <= upd_way_i;
    end
  end

  assign pred_way_o   = pred_q[rd_idx_i];
  assign victim_way_o = rr_q[fill_idx_i];
endmodule

// File: rtl/wp_hit_select.sv
module wp_hit_select
  import wp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [WAYS-1:0]             hit_i,
  input  logic [WAYS-1:0][DATA_W-1:0] data_i,
  output logic                        any_o,
  output logic [WAY_W-1:0]            way_o,
  output logic [DATA_W-1:0]           data_o
);
  always_comb begin
    any_o  = |hit_i;
    way_o  = '0;
    data_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_i[w]) begin
        way_o  = WAY_W'(w);
        data_o = data_o | data_i[w];
      end
    end
  end
endmodule

// File: rtl/wp_cache.sv
module wp_cache
  import wp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int SETS   = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              rsp_fast_o,
  output logic              rsp_slow_o,
  output logic              rsp_miss_o,
  input  logic              fill_valid_i,
  output logic              fill_ready_o,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [DATA_W-1:0] fill_data_i,
  output logic [WAYS-1:0]   tag_rd_en_o,
  output logic [WAYS-1:0]   data_rd_en_o,
  output logic [CNT_W-1:0]  pred_ok_cnt_o,
  output logic [CNT_W-1:0]  pred_bad_cnt_o
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  wp_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q;
  logic [TAG_W-1:0] tag_q;
  logic [WAY_W-1:0] pred_q, pred_rd, victim, hit_way;
  logic [WAYS-1:0]  pred_oh, rd_en, hit_vec;
  logic [WAYS-1:0][DATA_W-1:0] bank_data;
  logic [DATA_W-1:0] hit_data;
  logic             hit_any, req_fire, fill_fire;
  logic [CNT_W-1:0] ok_cnt_q, bad_cnt_q;

  assign fill_ready_o = (state_q == ST_IDLE);
  assign fill_fire    = fill_valid_i && fill_ready_o;
  assign req_ready_o  = (state_q == ST_IDLE) && !fill_valid_i;
  assign req_fire     = req_valid_i && req_ready_o;

  assign pred_oh = WAYS'(1) << pred_q;
  always_comb begin
    unique case (state_q)
      ST_PRED: rd_en = pred_oh;
      ST_REST: rd_en = ~pred_oh;
      default: rd_en = '0;
    endcase
  end
  assign tag_rd_en_o  = rd_en;
  assign data_rd_en_o = rd_en;

  wp_pred_table #(.SETS(SETS)) i_pred (
    .clk_i, .rst_ni,
    .rd_idx_i    (req_addr_i[IDX_W-1:0]),
    .pred_way_o  (pred_rd),
    .fill_en_i   (fill_fire),
    .fill_idx_i  (fill_addr_i[IDX_W-1:0]),
    .victim_way_o(victim),
    .upd_en_i    (rsp_slow_o),
    .upd_idx_i   (idx_q),
    .upd_way_i   (hit_way)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    wp_way_bank #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_bank (
      .clk_i, .rst_ni,
      .rd_en_i  (rd_en[w]),
      .rd_idx_i (idx_q),
      .rd_tag_i (tag_q),
      .hit_o    (hit_vec[w]),
      .rd_data_o(bank_data[w]),
      .wr_en_i  (fill_fire && (victim == WAY_W'(w))),
      .wr_idx_i (fill_addr_i[IDX_W-1:0]),
      .wr_tag_i (fill_addr_i[ADDR_W-1:IDX_W]),
      .wr_data_i(fill_data_i)
    );
  end

  wp_hit_select #(.DATA_W(DATA_W)) i_sel (
    .hit_i (hit_vec),
    .data_i(bank_data),
    .any_o (hit_any),
    .way_o (hit_way),
    .data_o(hit_data)
  );

  assign rsp_fast_o  = (state_q == ST_PRED) && hit_any;
  assign rsp_slow_o  = (state_q == ST_REST) && hit_any;
  assign rsp_miss_o  = (state_q == ST_REST) && !hit_any;
  assign rsp_valid_o = rsp_fast_o || rsp_slow_o || rsp_miss_o;
  assign rsp_data_o  = hit_data;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (req_fire) state_d = ST_PRED;
      ST_PRED: state_d = hit_any ? ST_IDLE : ST_REST;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      tag_q     <= '0;
      pred_q    <= '0;
      ok_cnt_q  <= '0;
      bad_cnt_q <= '0;
    end else begin
      state_q <= state_d;
      if (req_fire) begin
        idx_q  <= req_addr_i[IDX_W-1:0];
        tag_q  <= req_addr_i[ADDR_W-1:IDX_W];
        pred_q <= pred_rd;
      end
      if (rsp_fast_o) ok_cnt_q <= ok_cnt_q + 1'b1;
      if (rsp_slow_o || rsp_miss_o) bad_cnt_q <= bad_cnt_q + 1'b1;
    end
  end

  assign pred_ok_cnt_o  = ok_cnt_q;
  assign pred_bad_cnt_o = bad_cnt_q;
endmodule

// File: rtl/wp_cache_chk.sv
module wp_cache_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             fill_valid_i,
  input logic             fill_ready_o,
  input logic             rsp_valid_o,
  input logic             rsp_fast_o,
  input logic             rsp_slow_o,
  input logic             rsp_miss_o,
  input logic [3:0]       tag_rd_en_o,
  input logic [3:0]       data_rd_en_o,
  input logic [CNT_W-1:0] pred_ok_cnt_o,
  input logic [CNT_W-1:0] pred_bad_cnt_o
);
  assert_status_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rsp_fast_o, rsp_slow_o, rsp_miss_o}) &&
    (rsp_valid_o == (rsp_fast_o || rsp_slow_o || rsp_miss_o)));

  assert_probe_after_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> ($countones(tag_rd_en_o) == 1) && (data_rd_en_o == tag_rd_en_o));

  assert_fast_single_probe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fast_o |-> ($countones(tag_rd_en_o) == 1) && (data_rd_en_o == tag_rd_en_o));

  assert_rest_probe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_slow_o || rsp_miss_o) |-> ($countones($past(tag_rd_en_o)) == 1) &&
                                   (tag_rd_en_o == ~$past(tag_rd_en_o)));

  assert_fill_priority_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_i |-> !req_ready_o);

  assert_fill_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_ready_o |-> (tag_rd_en_o == 4'b0) && !rsp_valid_o);

  assert_ok_count_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fast_o |=> pred_ok_cnt_o == CNT_W'($past(pred_ok_cnt_o) + 1'b1));

  assert_bad_count_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_slow_o || rsp_miss_o) |=> pred_bad_cnt_o == CNT_W'($past(pred_bad_cnt_o) + 1'b1));
endmodule

bind wp_cache wp_cache_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .fill_valid_i, .fill_ready_o,
  .rsp_valid_o, .rsp_fast_o, .rsp_slow_o, .rsp_miss_o,
  .tag_rd_en_o, .data_rd_en_o, .pred_ok_cnt_o, .pred_bad_cnt_o
);

// File: tb/test_wp_cache.sv
module test_wp_cache;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;
  localparam logic [1:0] K_FAST = 2'd0, K_SLOW = 2'd1, K_MISS = 2'd2;

  // {addr, kind, expected data}
  localparam int NVEC = 6;
  localparam logic [49:0] VEC [NVEC] = '{
    {16'h0020, K_FAST, 32'h0000_00B0},  // set0 pred=1 after second fill
    {16'h0010, K_SLOW, 32'h0000_00A0},  // way0 while pred=1
    {16'h0010, K_FAST, 32'h0000_00A0},  // prediction moved to way0
    {16'h0031, K_FAST, 32'h0000_00C0},  // set1 untouched by set0 traffic
    {16'h0040, K_MISS, 32'h0000_0000},
    {16'h0039, K_MISS, 32'h0000_0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, fill_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0, fill_addr = '0;
  logic [DATA_W-1:0] fill_data = '0;
  logic req_ready, rsp_valid, rsp_fast, rsp_slow, rsp_miss, fill_ready;
  logic [DATA_W-1:0] rsp_data;
  logic [3:0] tag_en, data_en;
  logic [CNT_W-1:0] ok_cnt, bad_cnt;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  wp_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(8), .CNT_W(CNT_W)) i_wp_cache (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .rsp_fast_o(rsp_fast), .rsp_slow_o(rsp_slow), .rsp_miss_o(rsp_miss),
    .fill_valid_i(fill_valid), .fill_ready_o(fill_ready),
    .fill_addr_i(fill_addr), .fill_data_i(fill_data),
    .tag_rd_en_o(tag_en), .data_rd_en_o(data_en),
    .pred_ok_cnt_o(ok_cnt), .pred_bad_cnt_o(bad_cnt)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = a; fill_data = d;
    #1 check(req_ready == 1'b0, "R6 req_ready low under fill", 32'(req_ready), 0);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  // pred_way: expected first-probe way
  task automatic read(input logic [ADDR_W-1:0] a, input logic [1:0] kind,
                      input logic [DATA_W-1:0] d, input int pred_way, input string tag);
    logic [3:0] oh;
    oh = 4'(1 << pred_way);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check(tag_en == oh && data_en == oh, {tag, " R2 first probe way"}, 32'(tag_en), 32'(oh));
    check(fill_ready == 1'b0, {tag, " R6 fill blocked in flight"}, 32'(fill_ready), 0);
    if (kind == K_FAST) begin
      check(rsp_valid && rsp_fast && !rsp_slow && !rsp_miss, {tag, " R2 fast status"},
            32'({rsp_valid, rsp_fast, rsp_slow, rsp_miss}), 32'b1100);
      check(rsp_data == d, {tag, " R2 fast data"}, rsp_data, d);
    end else begin
      check(!rsp_valid, {tag, " R3 no response on mispredict"}, 32'(rsp_valid), 0);
      @(negedge clk);
      check(tag_en == ~oh && data_en == ~oh, {tag, " R3 rest probe"}, 32'(tag_en), 32'(~oh));
      if (kind == K_SLOW)
        check(rsp_valid && rsp_slow && !rsp_fast && !rsp_miss && rsp_data == d,
              {tag, " R3 slow hit"}, rsp_data, d);
      else
        check(rsp_valid && rsp_miss && !rsp_fast && !rsp_slow && rsp_data == '0,
              {tag, " R7 miss data zero"}, rsp_data, 0);
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #35 rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && fill_ready && !rsp_valid && tag_en == 0 && ok_cnt == 0 && bad_cnt == 0,
          "R1 reset state", 32'({req_ready, fill_ready, rsp_valid}), 32'b110);
    read(16'h0010, K_MISS, 0, 0, "R1 empty cache");

    fill(16'h0010, 32'h0000_00A0);  // set0 way0
    fill(16'h0020, 32'h0000_00B0);  // set0 way1, pred=1
    fill(16'h0031, 32'h0000_00C0);  // set1 way0

    for (int i = 0; i < NVEC; i++) begin
      int pw;
      // expected first-probe way per vector (R4/R5/R9)
      case (i)
        0: pw = 1;
        1: pw = 1;
        2: pw = 0;
        3: pw = 0;
        4: pw = 0;
        default: pw = 0;
      endcase
      read(VEC[i][49:34], VEC[i][33:32], VEC[i][31:0], pw, $sformatf("vec%0d", i));
    end

    // R5 round-robin victim and wrap
    fill(16'h0040, 32'h0000_00D0);  // way2, pred=2
    read(16'h0040, K_FAST, 32'h0000_00D0, 2, "R5 victim way2");
    fill(16'h0050, 32'h0000_00E0);  // way3
    read(16'h0050, K_FAST, 32'h0000_00E0, 3, "R5 victim way3");
    fill(16'h0060, 32'h0000_00F0);  // wraps to way0, evicts 0x0010
    read(16'h0060, K_FAST, 32'h0000_00F0, 0, "R5 wrap to way0");
    read(16'h0010, K_MISS, 0, 0, "R5 evicted line");
    // R4 slow hit then fast
    read(16'h0020, K_SLOW, 32'h0000_00B0, 0, "R4 slow hit");
    read(16'h0020, K_FAST, 32'h0000_00B0, 1, "R4 prediction follows");
    // R9 set1 still predicts way0
    read(16'h0031, K_FAST, 32'h0000_00C0, 0, "R9 set1 independent");

    @(negedge clk);
    // fast: vec0, vec2, vec3, 40, 50, 60, 20, 31 = 8; bad: first miss + vec1,4,5 + 10 miss + 20 slow = 6
    check(ok_cnt == 8, "R8 correct count", 32'(ok_cnt), 8);
    check(bad_cnt == 6, "R8 wrong count", 32'(bad_cnt), 6);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule